// File: doc/BRIEF.md
# Phase-Accumulating Waveform Synthesiser

This block produces one unsigned 8-bit sample for every update strobe that the converter interface issues. It never changes the update rate. Instead it sets the output frequency by the step that a phase accumulator adds on each strobe. The step is a fixed-point word with 7 integer bits and 8 fractional bits, so frequencies that are not whole-number fractions of the update rate can be reached. The fractional bits carry over from one update to the next. Only the 7 integer bits choose one of the 128 points in a waveform cycle.

There are four shapes. The sine shape reads a table that holds only the first quarter of the cycle; the other three quarters are made by mirroring the index and flipping the value about mid-scale. The ramp, the triangle and the square are computed directly from the phase. The chosen shape is then scaled toward mid-scale by an 8-bit amplitude, so a small amplitude shrinks the wave without moving its centre. A one-cycle valid pulse marks each new sample.

Top module: `wavegen_dds`

## Requirements
- R1: While reset is active and on release, the sample output is 128, valid is low, and the phase is zero, so the first sample after reset is taken at phase index 0.
- R2: Valid is high for exactly the one cycle after each clock edge where the strobe is high, and low otherwise. Without a strobe, the sample output and the phase hold their values, whatever the step, shape or amplitude inputs do.
- R3: Each strobe produces a sample from the phase as it stood before that strobe, then adds the 15-bit step to the phase modulo 2^15 (integer part modulo 128). The phase wraps and never saturates.
- R4: Fractional step bits (step[7:0]) accumulate and carry into the integer part. Only phase bits [14:8] choose the point in the cycle, so a step of 0x0080 presents each index on two consecutive strobes.
- R5: With shape code 0 (sine), the unscaled value at index p is 128 + round(127*sin(2*pi*p/128)) for p < 64 and 128 - round(127*|sin(2*pi*p/128)|) for p >= 64. It is built from a 33-entry quarter table: index bit 5 mirrors the table address to 32 - p[4:0], and index bit 6 flips the value about 128.
- R6: With shape code 1 (ramp), the unscaled value is 2*p.
- R7: With shape code 2 (triangle), the unscaled value is 4*p for p < 64 and 255 - 4*(p-64) for p >= 64.
- R8: With shape code 3 (square), the unscaled value is 255 for p < 64 and 0 for p >= 64.
- R9: The output equals floor((v - 128) * amp / 256) + 128, where v is the unscaled value. An amplitude of 0 gives 128, and an amplitude of 255 maps 255 to 254 and 0 to 0.
- R10: A new shape code takes effect at the next strobe and does not reset or disturb the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_stb | input | 1 | Update strobe from the converter interface |
| freq_inc | input | 15 | Phase step per update, 7.8 fixed point |
| wave_sel | input | 2 | Shape code: 0 sine, 1 ramp, 2 triangle, 3 square |
| amp | input | 8 | Amplitude scale, 0..255 out of 256 |
| sample_o | output | 8 | Scaled unsigned sample |
| sample_vld | output | 1 | One-cycle pulse marking a new sample |

## Verification
The phase cannot be seen at the ports. Two cases are therefore the hardest to reach and confirm: landing exactly on the quadrant seams of the folded table (indices 32, 64 and 96), and showing that fractional bits carry correctly. The stimulus starts from reset and uses a whole step of 32 to step straight onto the seams, then uses a step of one half so that each index appears twice in a row. It also uses steps near 127 and 0x7FFF to force wrap-around on almost every update. A behavioural model that runs alongside tracks the phase, so every later sample shows any drift that shape switches, idle gaps or input changes between strobes may have caused.

// File: rtl/wg_pkg.sv
`timescale 1ns/1ps
package wg_pkg;
    localparam int IDX_W = 7;
    localparam int SMP_W = 8;
    localparam int QTR_W = IDX_W - 1;

    typedef enum logic [1:0] {
        WAVE_SINE   = 2'd0,
        WAVE_RAMP   = 2'd1,
        WAVE_TRI    = 2'd2,
        WAVE_SQUARE = 2'd3
    } wave_e;
endpackage

// File: rtl/wg_phase_acc.sv
`timescale 1ns/1ps
module wg_phase_acc #(
    parameter int FRAC_W = 8,
    localparam int PH_W = wg_pkg::IDX_W + FRAC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_en,
    input  logic [PH_W-1:0] step,
    output logic [PH_W-1:0] phase
);
    // modulo wrap comes from the natural width of the register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (step_en) begin
            phase <= phase + step;
        end
    end
endmodule

// File: rtl/wg_shaper.sv
`timescale 1ns/1ps
module wg_shaper
    import wg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  wave_e            sel,
    output logic [SMP_W-1:0] shape
);
    // quarter-cycle magnitude, address 0..32
    function automatic logic [6:0] quarter_mag(input logic [QTR_W-1:0] k);
        case (k)
            6'd0:  return 7'd0;
            6'd1:  return 7'd6;
            6'd2:  return 7'd12;
            6'd3:  return 7'd19;
            6'd4:  return 7'd25;
            6'd5:  return 7'd31;
            6'd6:  return 7'd37;
            6'd7:  return 7'd43;
            6'd8:  return 7'd49;
            6'd9:  return 7'd54;
            6'd10: return 7'd60;
            6'd11: return 7'd65;
            6'd12: return 7'd71;
            6'd13: return 7'd76;
            6'd14: return 7'd81;
            6'd15: return 7'd85;
            6'd16: return 7'd90;
            6'd17: return 7'd94;
            6'd18: return 7'd98;
            6'd19: return 7'd102;
            6'd20: return 7'd106;
            6'd21: return 7'd109;
            6'd22: return 7'd112;
            6'd23: return 7'd115;
            6'd24: return 7'd117;
            6'd25: return 7'd120;
            6'd26: return 7'd122;
            6'd27: return 7'd123;
            6'd28: return 7'd125;
            6'd29: return 7'd126;
            6'd30: return 7'd126;
            6'd31: return 7'd127;
            6'd32: return 7'd127;
            default: return 7'd0;
        endcase
    endfunction

    logic [QTR_W-1:0] tbl_addr;
    logic [6:0]       mag;
    logic [SMP_W-1:0] sine_v;
    logic [SMP_W-1:0] tri_up;
    logic [SMP_W-1:0] tri_v;
    logic [SMP_W-1:0] ramp_v;
    logic [SMP_W-1:0] square_v;

    always_comb begin
        // second and fourth quarters read the table backwards
        if (idx[5]) begin
            tbl_addr = 6'd32 - {1'b0, idx[4:0]};
        end else begin
            tbl_addr = {1'b0, idx[4:0]};
        end
        mag = quarter_mag(tbl_addr);
        // second half of the cycle lies below mid-scale
        sine_v   = idx[6] ? (8'd128 - {1'b0, mag}) : (8'd128 + {1'b0, mag});
        ramp_v   = {idx, 1'b0};
        tri_up   = {idx[5:0], 2'b00};
        tri_v    = idx[6] ? ~tri_up : tri_up;
        square_v = idx[6] ? 8'd0 : 8'd255;
    end

    always_comb begin
        unique case (sel)
            WAVE_SINE:   shape = sine_v;
            WAVE_RAMP:   shape = ramp_v;
            WAVE_TRI:    shape = tri_v;
            WAVE_SQUARE: shape = square_v;
            default:     shape = sine_v;
        endcase
    end
endmodule

// File: rtl/wg_scaler.sv
`timescale 1ns/1ps
module wg_scaler #(
    parameter int AMP_W = 8,
    localparam int PW = AMP_W + 11
) (
    input  logic [wg_pkg::SMP_W-1:0] raw,
    input  logic [AMP_W-1:0]         amp,
    output logic [wg_pkg::SMP_W-1:0] scaled
);
    logic signed [9:0]    centred;
    logic signed [PW-1:0] cen_x;
    logic signed [PW-1:0] amp_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        centred = $signed({2'b00, raw}) - 10'sd128;
        cen_x   = PW'(centred);
        amp_x   = $signed({{(PW-AMP_W){1'b0}}, amp});
        prod    = cen_x * amp_x;
        // arithmetic shift gives floor division for negative products
        shifted = prod >>> AMP_W;
        scaled  = shifted[7:0] + 8'd128;
    end
endmodule

// File: rtl/wavegen_dds.sv
`timescale 1ns/1ps
module wavegen_dds #(
    parameter int FRAC_W = 8,
    parameter int AMP_W  = 8,
    localparam int PH_W  = wg_pkg::IDX_W + FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd_stb,
    input  logic [PH_W-1:0]          freq_inc,
    input  logic [1:0]               wave_sel,
    input  logic [AMP_W-1:0]         amp,
    output logic [wg_pkg::SMP_W-1:0] sample_o,
    output logic                     sample_vld
);
    import wg_pkg::*;

    logic [PH_W-1:0]  phase_w;
    logic [IDX_W-1:0] idx_w;
    logic [SMP_W-1:0] shape_w;
    logic [SMP_W-1:0] scaled_w;

    wg_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (upd_stb),
        .step    (freq_inc),
        .phase   (phase_w)
    );

    assign idx_w = phase_w[PH_W-1:FRAC_W];

    wg_shaper u_shape (
        .idx   (idx_w),
        .sel   (wave_e'(wave_sel)),
        .shape (shape_w)
    );

    wg_scaler #(.AMP_W(AMP_W)) u_scale (
        .raw    (shape_w),
        .amp    (amp),
        .scaled (scaled_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_o   <= 8'd128;
            sample_vld <= 1'b0;
        end else begin
            sample_vld <= upd_stb;
            if (upd_stb) begin
                sample_o <= scaled_w;
            end
        end
    end
endmodule

// File: rtl/wavegen_dds_checker.sv
`timescale 1ns/1ps
module wavegen_dds_checker #(
    parameter int FRAC_W = 8,
    parameter int AMP_W  = 8,
    localparam int PH_W  = wg_pkg::IDX_W + FRAC_W,
    localparam int SQ_HI = ((((2 ** AMP_W) - 1) * 127) >> AMP_W) + 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_stb,
    input logic [1:0]       wave_sel,
    input logic [AMP_W-1:0] amp,
    input logic [7:0]       sample_o,
    input logic             sample_vld,
    input logic [PH_W-1:0]  phase
);
    a_r1_reset_release: assert property (@(posedge clk)
        $rose(rst_n) |-> (sample_o == 8'd128 && !sample_vld && phase == '0));

    a_r2_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> sample_vld);

    a_r2_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |=> (!sample_vld && $stable(sample_o)));

    a_r3_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |=> $stable(phase));

    a_r9_zero_amp_midscale: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && amp == '0) |=> sample_o == 8'd128);

    a_r8_square_two_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && wave_sel == 2'd3 && amp == '1) |=>
            (sample_o == 8'd0 || sample_o == 8'(SQ_HI)));
endmodule

bind wavegen_dds wavegen_dds_checker #(.FRAC_W(FRAC_W), .AMP_W(AMP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_stb    (upd_stb),
    .wave_sel   (wave_sel),
    .amp        (amp),
    .sample_o   (sample_o),
    .sample_vld (sample_vld),
    .phase      (phase_w)
);

// File: tb/wavegen_dds_bench.sv
`timescale 1ns/1ps
module wavegen_dds_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_stb = 1'b0;
    logic [14:0] freq_inc = '0;
    logic [1:0]  wave_sel = '0;
    logic [7:0]  amp = '0;
    logic [7:0]  sample_o;
    logic        sample_vld;

    always #5 clk = ~clk;

    wavegen_dds u_wavegen_dds (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_stb    (upd_stb),
        .freq_inc   (freq_inc),
        .wave_sel   (wave_sel),
        .amp        (amp),
        .sample_o   (sample_o),
        .sample_vld (sample_vld)
    );

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    cmp_en = 1'b0;
    bit    finished = 1'b0;

    int m_phase = 0;
    int exp_s = 128;
    bit exp_v = 1'b0;

    function automatic int sine_ref(int p);
        real s;
        int  m;
        s = 127.0 * $sin(2.0 * 3.14159265358979 * p / 128.0);
        m = $rtoi(((s < 0.0) ? -s : s) + 0.5);
        return (s < 0.0) ? 128 - m : 128 + m;
    endfunction

    function automatic int shape_ref(int p, int sel);
        case (sel)
            0: return sine_ref(p);
            1: return 2 * p;
            2: return (p < 64) ? 4 * p : 255 - 4 * (p - 64);
            default: return (p < 64) ? 255 : 0;
        endcase
    endfunction

    function automatic int scale_ref(int v, int a);
        int prod;
        int q;
        prod = (v - 128) * a;
        q = (prod >= 0) ? prod / 256 : -((-prod + 255) / 256);
        return q + 128;
    endfunction

    // behavioural reference, advanced on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            exp_s = 128;
            exp_v = 1'b0;
        end else if (upd_stb) begin
            exp_s = scale_ref(shape_ref(m_phase / 256, wave_sel), amp);
            exp_v = 1'b1;
            m_phase = (m_phase + freq_inc) % 32768;
        end else begin
            exp_v = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            checks++;
            if (sample_vld !== exp_v || sample_o !== exp_s[7:0]) begin
                fails++;
                $display("FAIL %s model compare: actual sample=%0d vld=%0b expected sample=%0d vld=%0b",
                         cur_req, sample_o, sample_vld, exp_s, exp_v);
            end
        end
    end

    task automatic spot(input string req, input int expv);
        checks++;
        if (sample_o !== expv[7:0]) begin
            fails++;
            $display("FAIL %s spot: actual=%0d expected=%0d", req, sample_o, expv);
        end
    endtask

    task automatic strobe(input logic [14:0] inc, input logic [1:0] sel,
                          input logic [7:0] a, input int gap);
        @(negedge clk);
        freq_inc = inc;
        wave_sel = sel;
        amp = a;
        upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmp_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        checks++;
        if (sample_o !== 8'd128 || sample_vld !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual sample=%0d vld=%0b expected sample=128 vld=0",
                     sample_o, sample_vld);
        end
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R5 quadrant seams from phase 0 with step 32.0
        cur_req = "R5";
        strobe(15'h2000, 2'd0, 8'd255, 0); spot("R5", 128);
        strobe(15'h2000, 2'd0, 8'd255, 0); spot("R5", 254);
        strobe(15'h2000, 2'd0, 8'd255, 0); spot("R5", 128);
        strobe(15'h2000, 2'd0, 8'd255, 0); spot("R5", 1);
        for (int i = 0; i < 130; i++) strobe(15'h0100, 2'd0, 8'd255, 0);

        cur_req = "R6";
        for (int i = 0; i < 50; i++) strobe(15'h0300, 2'd1, 8'd200, 1);

        cur_req = "R7";
        for (int i = 0; i < 60; i++) strobe(15'h0540, 2'd2, 8'd255, 0);

        cur_req = "R8";
        for (int i = 0; i < 40; i++) strobe(15'h0700, 2'd3, (i < 20) ? 8'd255 : 8'd100, 0);

        cur_req = "R9";
        strobe(15'h0B00, 2'd0, 8'd0, 0); spot("R9", 128);
        for (int i = 0; i < 40; i++) strobe(15'h0B00, 2'd0, 8'd17, 0);
        for (int i = 0; i < 40; i++) strobe(15'h0900, 2'd2, 8'd128, 0);

        // R4 half-step from a known phase
        do_reset();
        cur_req = "R4";
        strobe(15'h0080, 2'd1, 8'd255, 0); spot("R4", 0);
        strobe(15'h0080, 2'd1, 8'd255, 0); spot("R4", 0);
        strobe(15'h0080, 2'd1, 8'd255, 0); spot("R4", 2);
        strobe(15'h0080, 2'd1, 8'd255, 0); spot("R4", 2);
        for (int i = 0; i < 40; i++) strobe(15'h01C3, 2'd0, 8'd255, 0);

        cur_req = "R3";
        for (int i = 0; i < 40; i++) strobe(15'h7F00, 2'd1, 8'd255, 0);
        for (int i = 0; i < 40; i++) strobe(15'h7FFF, 2'd2, 8'd240, 0);

        // R2 inputs moving between strobes must not matter
        cur_req = "R2";
        for (int i = 0; i < 20; i++) begin
            strobe(15'h0A00, 2'd0, 8'd255, 0);
            freq_inc = 15'(i * 1234);
            wave_sel = 2'(i);
            amp = 8'(i * 13);
            repeat (3) @(negedge clk);
        end

        cur_req = "R10";
        for (int i = 0; i < 48; i++) strobe(15'h0500, 2'(i % 4), 8'd230, i % 3);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL %s watchdog: actual=running expected=done", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule